// File: doc/BRIEF.md
# Hierarchical Region Merge Scheduler

This block drives the merge phase of a row-parallel connected-component labeler for an image of `N_ROWS` rows, `N_ROWS` a power of two. Between each pair of neighbouring rows sits one comparator element, so there are `N_ROWS-1` of them. Each element looks at the column-0 labels of its two rows. When it is active and the labels differ, it produces a replacement pair: the smaller label is the new value and the larger one is the key. A switch tree then delivers that pair to every row of the two regions that meet at that element.

Merging runs in `log2(N_ROWS)-1` stages, one after another. In stage k, the rows form aligned groups of `2^k` rows. In each group, only the element at the middle boundary is enabled. Each stage lasts `N_ROWS` iterations of one clock cycle each. The row storage lives outside the block. During every busy cycle it applies the broadcast update (each cell equal to the key takes the new value) and then rotates its row left by one position, on the `shift` strobe. This block supplies only the sequencing, the compare and the broadcast enables.

Top module: `merge_sched_top`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `shift`, `stage` and every `upd_en` bit are 0.
- R2: A `start` seen while idle makes `busy` high from the next cycle for exactly `(log2(N_ROWS)-1) * N_ROWS` consecutive cycles, and `shift` is high in every one of those cycles.
- R3: While busy, `stage` holds k = 1 for the first `N_ROWS` cycles and then steps by one every `N_ROWS` cycles up to `log2(N_ROWS)-1`. While idle, `stage` is 0.
- R4: When a row's update is enabled, `upd_new` is the smaller and `upd_key` the larger of the two column-0 labels compared by that row's group element.
- R5: No update is enabled when the two compared labels are equal or when either of them is zero.
- R6: In stage k, row r is served by element `e = (r - r mod 2^k) + 2^(k-1) - 1`, which compares rows e and e+1. All `2^k` rows of that group carry the same enable and the same pair. Stage k therefore enables elements 2^(k-1)-1, plus multiples of 2^k above that.
- R7: `done` pulses high for one cycle, in the cycle right after the last busy cycle, with `busy` low.
- R8: A `start` raised while busy is ignored and does not lengthen or restart the run.
- R9: While idle, `shift` and all `upd_en` bits stay low, whatever labels are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a merge run |
| row_lbl | input | N_ROWS x LBL_W | Column-0 label of each row |
| busy | output | 1 | Merge run in progress |
| done | output | 1 | One-cycle pulse after the final iteration |
| shift | output | 1 | Rows rotate left by one at this edge |
| stage | output | STG_W | Current merge stage, 0 when idle |
| upd_en | output | N_ROWS | Per-row broadcast update enable |
| upd_new | output | N_ROWS x LBL_W | Per-row replacement label |
| upd_key | output | N_ROWS x LBL_W | Per-row label to be replaced |

## Verification
Two things can happen in the same cycle: an update broadcast that rewrites a row, and the left rotation of that same row. The bench therefore acts as the row storage. At each edge it applies the replacement first and the rotation second, so every later column-0 label depends on both having been ordered correctly. The reference model predicts the enables and pairs cycle by cycle from those same rows, so any misordering or misrouting shows up as a mismatch on a later iteration. A second overlap is the last iteration of a stage, where the stage advance, the final broadcast and the shift all fall together. This is judged by comparing `stage`, `busy` and `done` against the model on every cycle at that boundary.

// File: rtl/merge_sched_pkg.sv
package merge_sched_pkg;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    // Element serving a row in a given stage (stage >= 1).
    function automatic int grp_owner(input int row, input int stg);
        if (stg < 1) return 0;
        return ((row >> stg) << stg) + (1 << (stg - 1)) - 1;
    endfunction

    // True when an element sits on the middle boundary of its group.
    function automatic logic elem_on(input int elem, input int stg);
        if (stg < 1) return 1'b0;
        return ((elem + 1) % (1 << stg)) == (1 << (stg - 1));
    endfunction

endpackage

// File: rtl/merge_seq.sv
module merge_seq
    import merge_sched_pkg::*;
#(
    parameter int N_ROWS   = 8,
    parameter int N_STAGES = 2,
    parameter int STG_W    = 2,
    localparam int IT_W    = $clog2(N_ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [STG_W-1:0] stage
);

    seq_state_e      st;
    logic [IT_W-1:0] it;
    logic            done_q;
    logic [STG_W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            stg    <= '0;
            it     <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st  <= SQ_RUN;
                        stg <= STG_W'(1);
                        it  <= '0;
                    end
                end
                SQ_RUN: begin
                    if (it == IT_W'(N_ROWS - 1)) begin
                        it <= '0;
                        if (stg == STG_W'(N_STAGES)) begin
                            st     <= SQ_IDLE;
                            stg    <= '0;
                            done_q <= 1'b1;
                        end else begin
                            stg <= stg + 1'b1;
                        end
                    end else begin
                        it <= it + 1'b1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy  = (st == SQ_RUN);
    assign done  = done_q;
    assign stage = stg;

endmodule

// File: rtl/merge_pe.sv
module merge_pe #(
    parameter int LBL_W = 6
) (
    input  logic             act,
    input  logic [LBL_W-1:0] lbl_lo,
    input  logic [LBL_W-1:0] lbl_hi,
    output logic             vld,
    output logic [LBL_W-1:0] val_new,
    output logic [LBL_W-1:0] val_key
);

    logic a_small;

    always_comb begin
        a_small = (lbl_lo < lbl_hi);
        val_new = a_small ? lbl_lo : lbl_hi;
        val_key = a_small ? lbl_hi : lbl_lo;
        vld     = act && (lbl_lo != lbl_hi)
                      && (lbl_lo != '0) && (lbl_hi != '0);
    end

endmodule

// File: rtl/merge_tree.sv
module merge_tree
    import merge_sched_pkg::*;
#(
    parameter int N_ROWS = 8,
    parameter int LBL_W  = 6,
    parameter int STG_W  = 2,
    localparam int N_PE  = N_ROWS - 1,
    localparam int EW    = $clog2(N_PE)
) (
    input  logic [STG_W-1:0]           stage,
    input  logic [N_PE-1:0]            pe_vld,
    input  logic [N_PE-1:0][LBL_W-1:0] pe_new,
    input  logic [N_PE-1:0][LBL_W-1:0] pe_key,
    output logic [N_ROWS-1:0]            row_en,
    output logic [N_ROWS-1:0][LBL_W-1:0] row_new,
    output logic [N_ROWS-1:0][LBL_W-1:0] row_key
);

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        logic [EW-1:0] sel;
        always_comb begin
            sel = EW'(grp_owner(r, int'(stage)));
            if (stage == '0) begin
                row_en[r]  = 1'b0;
                row_new[r] = '0;
                row_key[r] = '0;
            end else begin
                row_en[r]  = pe_vld[sel];
                row_new[r] = pe_new[sel];
                row_key[r] = pe_key[sel];
            end
        end
    end

endmodule

// File: rtl/merge_sched_top.sv
module merge_sched_top
    import merge_sched_pkg::*;
#(
    parameter int N_ROWS   = 8,
    localparam int LOG_N   = $clog2(N_ROWS),
    localparam int LBL_W   = 2 * LOG_N,
    localparam int N_STAGES = LOG_N - 1,
    localparam int STG_W   = $clog2(N_STAGES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [N_ROWS-1:0][LBL_W-1:0] row_lbl,
    output logic                        busy,
    output logic                        done,
    output logic                        shift,
    output logic [STG_W-1:0]            stage,
    output logic [N_ROWS-1:0]            upd_en,
    output logic [N_ROWS-1:0][LBL_W-1:0] upd_new,
    output logic [N_ROWS-1:0][LBL_W-1:0] upd_key
);

    localparam int N_PE = N_ROWS - 1;

    logic [N_PE-1:0]            pe_vld;
    logic [N_PE-1:0][LBL_W-1:0] pe_new;
    logic [N_PE-1:0][LBL_W-1:0] pe_key;

    merge_seq #(
        .N_ROWS  (N_ROWS),
        .N_STAGES(N_STAGES),
        .STG_W   (STG_W)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .busy (busy),
        .done (done),
        .stage(stage)
    );

    assign shift = busy;

    for (genvar e = 0; e < N_PE; e++) begin : g_pe
        logic act;
        assign act = busy && elem_on(e, int'(stage));
        merge_pe #(.LBL_W(LBL_W)) u_pe (
            .act    (act),
            .lbl_lo (row_lbl[e]),
            .lbl_hi (row_lbl[e+1]),
            .vld    (pe_vld[e]),
            .val_new(pe_new[e]),
            .val_key(pe_key[e])
        );
    end

    merge_tree #(
        .N_ROWS(N_ROWS),
        .LBL_W (LBL_W),
        .STG_W (STG_W)
    ) u_tree (
        .stage  (stage),
        .pe_vld (pe_vld),
        .pe_new (pe_new),
        .pe_key (pe_key),
        .row_en (upd_en),
        .row_new(upd_new),
        .row_key(upd_key)
    );

endmodule

// File: rtl/merge_sched_chk.sv
module merge_sched_chk #(
    parameter int N_ROWS   = 8,
    parameter int LBL_W    = 6,
    parameter int N_STAGES = 2,
    parameter int STG_W    = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        busy,
    input logic                        done,
    input logic                        shift,
    input logic [STG_W-1:0]            stage,
    input logic [N_ROWS-1:0]            upd_en,
    input logic [N_ROWS-1:0][LBL_W-1:0] upd_new,
    input logic [N_ROWS-1:0][LBL_W-1:0] upd_key
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (upd_en == '0 && !shift)); // R9

    AST_RUN_SHIFTS: assert property (@(posedge clk) disable iff (rst)
        busy |-> shift); // R2

    AST_STAGE_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (stage >= STG_W'(1) && stage <= STG_W'(N_STAGES))); // R3

    AST_IDLE_STAGE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> stage == '0); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R7

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        AST_MIN_MAX: assert property (@(posedge clk) disable iff (rst)
            upd_en[r] |-> upd_new[r] < upd_key[r]); // R4
        AST_NO_ZERO: assert property (@(posedge clk) disable iff (rst)
            upd_en[r] |-> upd_new[r] != '0); // R5
        if (r % 2 == 0) begin : g_pair
            AST_PAIR_SHARED: assert property (@(posedge clk) disable iff (rst)
                upd_en[r] |-> (upd_en[r+1] && upd_new[r] == upd_new[r+1]
                               && upd_key[r] == upd_key[r+1])); // R6
        end
    end

endmodule

bind merge_sched_top merge_sched_chk #(
    .N_ROWS  (N_ROWS),
    .LBL_W   (LBL_W),
    .N_STAGES(N_STAGES),
    .STG_W   (STG_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .done   (done),
    .shift  (shift),
    .stage  (stage),
    .upd_en (upd_en),
    .upd_new(upd_new),
    .upd_key(upd_key)
);

// File: tb/test_merge_sched_top.sv
`timescale 1ns/1ps
module test_merge_sched_top;

    localparam int N = 8;
    localparam int W = 6;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [N-1:0][W-1:0] row_lbl;
    logic busy, done, shift;
    logic [1:0] stage;
    logic [N-1:0] upd_en;
    logic [N-1:0][W-1:0] upd_new, upd_key;

    always #5 clk = ~clk;

    merge_sched_top #(.N_ROWS(N)) i_merge_sched_top (
        .clk(clk), .rst(rst), .start(start), .row_lbl(row_lbl),
        .busy(busy), .done(done), .shift(shift), .stage(stage),
        .upd_en(upd_en), .upd_new(upd_new), .upd_key(upd_key)
    );

    // Row storage held by the bench
    int mem [N][N];
    always_comb for (int r = 0; r < N; r++) row_lbl[r] = W'(mem[r][0]);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int busy_cnt = 0;
    int done_cnt = 0;
    int en_cnt = 0;

    // Reference state
    int rbusy = 0, rstage = 0, riter = 0, rdone = 0;

    // Captured outputs applied to storage at the next edge
    logic         cap_shift = 1'b0;
    logic [N-1:0] cap_en = '0;
    int           cap_new [N];
    int           cap_key [N];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Storage update and reference step at the clock edge
    always @(posedge clk) begin
        if (rst) begin
            rbusy = 0; rstage = 0; riter = 0; rdone = 0;
        end else begin
            for (int r = 0; r < N; r++) begin
                if (cap_en[r])
                    for (int c = 0; c < N; c++)
                        if (mem[r][c] == cap_key[r]) mem[r][c] = cap_new[r];
                if (cap_shift) begin
                    int first;
                    first = mem[r][0];
                    for (int c = 0; c < N - 1; c++) mem[r][c] = mem[r][c+1];
                    mem[r][N-1] = first;
                end
            end
            rdone = 0;
            if (rbusy == 0) begin
                if (start) begin rbusy = 1; rstage = 1; riter = 0; end
            end else if (riter == N - 1) begin
                riter = 0;
                if (rstage == S) begin rbusy = 0; rstage = 0; rdone = 1; end
                else rstage = rstage + 1;
            end else begin
                riter = riter + 1;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R2 watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (!rst) begin
            chk("R2 busy", int'(busy), rbusy);
            chk("R2 shift", int'(shift), rbusy);
            chk("R3 stage", int'(stage), rstage);
            chk("R7 done", int'(done), rdone);
            for (int r = 0; r < N; r++) begin
                int blk, e, a, b, xen;
                xen = 0; a = 0; b = 0;
                if (rbusy != 0) begin
                    blk = 1 << rstage;
                    e = r - (r % blk) + blk / 2 - 1;
                    a = mem[e][0]; b = mem[e+1][0];
                    xen = (a != b && a != 0 && b != 0) ? 1 : 0;
                end
                if (rbusy == 0) chk("R9 upd_en idle", int'(upd_en[r]), 0);
                else if (xen == 0) chk("R5 upd_en suppressed", int'(upd_en[r]), 0);
                else begin
                    chk("R6 upd_en group", int'(upd_en[r]), 1);
                    chk("R4 upd_new min", int'(upd_new[r]), (a < b) ? a : b);
                    chk("R4 upd_key max", int'(upd_key[r]), (a < b) ? b : a);
                end
            end
            if (busy) busy_cnt++;
            if (done) done_cnt++;
            en_cnt += $countones(upd_en);
        end
        cap_shift = shift;
        cap_en    = upd_en;
        for (int r = 0; r < N; r++) begin
            cap_new[r] = int'(upd_new[r]);
            cap_key[r] = int'(upd_key[r]);
        end
    end

    task automatic load(input int pat);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                case (pat)
                    0: mem[r][c] = 0;
                    1: mem[r][c] = (c < 5 && ((r + c) % 3 != 0)) ? ((r * N + c) % 13 + 1) : 0;
                    2: mem[r][c] = ((r + 2 * c) % 4 == 0) ? 0 : ((r * 5 + c * 3) % 11 + 1);
                    3: mem[r][c] = 7;
                    default: mem[r][c] = (c % 2 == 0) ? (r + 1) : 0;
                endcase
            end
    endtask

    task automatic run(input bit poke);
        busy_cnt = 0; done_cnt = 0; en_cnt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (N + 3) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        load(0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 shift", int'(shift), 0);
        chk("R1 stage", int'(stage), 0);
        chk("R1 upd_en", int'(upd_en), 0);
        rst = 1'b0;

        // R9: idle with differing labels yields nothing
        load(4);
        repeat (4) @(negedge clk);
        chk("R9 idle enables", en_cnt, 0);

        load(1);
        run(1'b0);
        chk("R2 run length", busy_cnt, S * N);
        chk("R7 done count", done_cnt, 1);

        // R8: start during run is ignored
        load(2);
        run(1'b1);
        chk("R8 run length with extra start", busy_cnt, S * N);
        chk("R8 done count", done_cnt, 1);

        // R5: all zero and all equal images never update
        load(0);
        run(1'b0);
        chk("R5 zero image enables", en_cnt, 0);
        load(3);
        run(1'b0);
        chk("R5 equal image enables", en_cnt, 0);

        // R6: distinct labels per row force updates in both stages
        load(4);
        run(1'b0);
        checks++;
        if (en_cnt == 0) begin
            errors++;
            $display("FAIL R6 enable count actual %0d expected nonzero", en_cnt);
        end
        chk("R6 rows 0 and 1 merged", mem[1][0], mem[0][0]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule